// File: doc/BRIEF.md
# Banked Host Register File for a Network Controller

This block is the register window that a host processor sees on a network controller. The host presents a 4-bit offset with a strobe and a direction. It can move either a single byte or a 16-bit word. The lower eight offsets always reach the same resident registers: an event status register, an interrupt mask, general control bytes, a bus configuration byte and a bank/control byte. The upper eight offsets are steered by a 2-bit bank field. That field selects station-address and diagnostic storage, multicast hash storage, or a buffer-access bank. In the buffer-access bank, offset 8 is a data port onto external transmit and receive FIFOs.

The FIFOs sit outside the block. A write to the data port raises a push strobe and presents the outgoing bytes. A read raises a pop strobe and returns the bytes the receive FIFO shows at its head. In 16-bit mode, one word access moves two FIFO bytes. The configuration byte chooses 8-bit or 16-bit bus operation, and it chooses which lane carries the lower-offset byte of a word. The interrupt output is the OR of the status bits that are enabled by the mask.

Top module: `nic_host_regs`

## Requirements
- R1: While rst_n is low, and after it is released, every register reads 0x00, irq is low and no push or pop strobe is raised. rdata is 0x0000 whenever no read is in progress.
- R2: Offsets 0 to 7 read back what was last written, whatever the bank field holds. The exception is offset 0, whose behaviour is set by R9.
- R3: Bits [3:2] of offset 7 form the bank field: 00 selects station address and diagnostics, 01 the hash table, 10 buffer access, 11 nothing. With 11, offsets 8 to 15 read 0x00 and writes to them change no storage.
- R4: Bank 00 and bank 01 each hold eight independent bytes at offsets 8 to 15. A write in one bank leaves the other unchanged.
- R5: In bank 10, a write to offset 8 raises tx_push with the data on tx_data. A read of offset 8 raises rx_pop and returns rx_rdata. Offsets 9 to 15 of that bank read 0x00 and store nothing.
- R6: Bit 0 of offset 6 selects the bus: 1 for 16-bit, 0 for 8-bit. In 8-bit mode a word request acts as a byte access at addr itself. A byte access uses wdata[7:0] and returns its byte on rdata[7:0], with rdata[15:8] at 0x00.
- R7: A 16-bit access covers offsets addr with bit 0 cleared and addr with bit 0 set. Bit 1 of offset 6 sets the lane order: 0 puts the lower offset on [7:0], and 1 puts it on [15:8].
- R8: A 16-bit access to the data port raises tx_two or rx_two and moves two FIFO bytes. The first FIFO byte is on [7:0] of tx_data and rx_rdata and is the lower-offset lane. An 8-bit access moves one byte on [7:0], and tx_data[15:8] is 0x00.
- R9: Offset 0 is the status register. A bit is set by a 1 on status_set. It is cleared by writing 1 to it. When a set and a clear of the same bit happen in one cycle, the set wins.
- R10: irq is high exactly when some bit is 1 in both status (offset 0) and mask (offset 1). irq follows register state.
- R11: The push and pop strobes rise only for accesses to offset 8 in bank 10, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Access strobe, one access per cycle |
| we | input | 1 | 1 for a write, 0 for a read |
| wide | input | 1 | Requests a 16-bit access |
| addr | input | 4 | Register offset |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle of the read |
| status_set | input | 8 | Per-bit status event pulses |
| irq | output | 1 | Interrupt request |
| tx_push | output | 1 | Transmit FIFO push strobe |
| tx_two | output | 1 | The push carries two bytes |
| tx_data | output | 16 | Bytes for the transmit FIFO, first byte in [7:0] |
| rx_pop | output | 1 | Receive FIFO pop strobe |
| rx_two | output | 1 | The pop takes two bytes |
| rx_rdata | input | 16 | Head bytes of the receive FIFO, first byte in [7:0] |

## Verification
The assertions assume that cs, we, wide, addr and status_set are always at known levels, and that rx_rdata holds valid head bytes whenever a pop can occur. The block has no empty flag, so the host is relied on never to read an empty FIFO. The stimulus meets these assumptions: it drives every input to a defined value in every cycle and places a fresh random value on rx_rdata for each access, as a FIFO that is never empty would. Random accesses also rewrite the configuration and bank bytes, so the steering and lane-order rules are checked under every mode the block can enter.

// File: rtl/nic_host_regs.sv
module nic_host_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs,
  input  logic        we,
  input  logic        wide,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic [7:0]  status_set,
  output logic        irq,
  output logic        tx_push,
  output logic        tx_two,
  output logic [15:0] tx_data,
  output logic        rx_pop,
  output logic        rx_two,
  input  logic [15:0] rx_rdata
);

  logic [63:0] dreg, bka, bkb;
  logic [1:0]  bank;
  logic        bus16, msbf, wmode, fifo_hit;
  logic [3:0]  la [2];
  logic [7:0]  wb [2];
  logic [7:0]  rb [2];
  logic [1:0]  lw;
  logic [7:0]  clr;

  assign bus16 = dreg[48];
  assign msbf  = dreg[49];
  assign bank  = dreg[59:58];
  assign wmode = wide & bus16;

  assign la[0] = wmode ? {addr[3:1], 1'b0} : addr;
  assign la[1] = {addr[3:1], 1'b1};
  assign wb[0] = (wmode && msbf) ? wdata[15:8] : wdata[7:0];
  assign wb[1] = msbf ? wdata[7:0] : wdata[15:8];

  assign fifo_hit = cs && (bank == 2'b10) && (la[0] == 4'd8);

  function automatic logic [7:0] peek(input logic [3:0] a);
    if (!a[3]) return dreg[{a[2:0], 3'b000} +: 8];
    case (bank)
      2'b00:   return bka[{a[2:0], 3'b000} +: 8];
      2'b01:   return bkb[{a[2:0], 3'b000} +: 8];
      default: return 8'h00;
    endcase
  endfunction

  assign rb[0] = fifo_hit ? rx_rdata[7:0]  : peek(la[0]);
  assign rb[1] = fifo_hit ? rx_rdata[15:8] : peek(la[1]);

  assign rdata = !(cs && !we) ? 16'h0000 :
                 !wmode       ? {8'h00, rb[0]} :
                 msbf         ? {rb[0], rb[1]} : {rb[1], rb[0]};

  assign tx_push = fifo_hit && we;
  assign rx_pop  = fifo_hit && !we;
  assign tx_two  = tx_push && wmode;
  assign rx_two  = rx_pop && wmode;
  assign tx_data = wmode ? {wb[1], wb[0]} : {8'h00, wb[0]};

  assign lw[0] = cs && we && !fifo_hit;
  assign lw[1] = lw[0] && wmode;
  assign clr   = (lw[0] && la[0] == 4'd0) ? wb[0] : 8'h00;

  assign irq = |(dreg[7:0] & dreg[15:8]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dreg <= '0;
      bka  <= '0;
      bkb  <= '0;
    end else begin
      for (int l = 0; l < 2; l++) begin
        if (lw[l]) begin
          if (!la[l][3]) begin
            if (la[l][2:0] != 3'd0) dreg[{la[l][2:0], 3'b000} +: 8] <= wb[l];
          end else if (bank == 2'b00) begin
            bka[{la[l][2:0], 3'b000} +: 8] <= wb[l];
          end else if (bank == 2'b01) begin
            bkb[{la[l][2:0], 3'b000} +: 8] <= wb[l];
          end
        end
      end
      dreg[7:0] <= (dreg[7:0] & ~clr) | status_set;
    end
  end

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_push && rx_pop));

  p_two_needs_wide_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_two || rx_two) |-> (cs && wide));

  p_dead_bank_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && bank == 2'b11 && addr[3]) |-> (rdata == 16'h0000));

  p_dead_bank_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && bank == 2'b11 && addr[3]) |=> ($stable(bka) && $stable(bkb)));

  p_status_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_set != 8'h00) |=> ((dreg[7:0] & $past(status_set)) == $past(status_set)));

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((status_set != 8'h00) || (cs && we)));

  p_byte_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && !wide) |-> (rdata[15:8] == 8'h00));

endmodule

// File: tb/nic_host_regs_test.sv
module nic_host_regs_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0, wide = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0, rx_rdata = '0;
  logic [7:0]  status_set = '0;
  logic [15:0] rdata, tx_data;
  logic irq, tx_push, tx_two, rx_pop, rx_two;

  int checks = 0, fails = 0;
  logic [7:0] mdir [8];
  logic [7:0] mba  [8];
  logic [7:0] mbb  [8];
  logic [15:0] got;

  always #5 clk = ~clk;

  nic_host_regs uut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .wide(wide), .addr(addr),
    .wdata(wdata), .rdata(rdata), .status_set(status_set), .irq(irq),
    .tx_push(tx_push), .tx_two(tx_two), .tx_data(tx_data),
    .rx_pop(rx_pop), .rx_two(rx_two), .rx_rdata(rx_rdata));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [3:0] a, input logic [1:0] bk);
    if (!a[3]) return mdir[a[2:0]];
    if (bk == 2'b00) return mba[a[2:0]];
    if (bk == 2'b01) return mbb[a[2:0]];
    return 8'h00;
  endfunction

  task automatic acc(input bit w, input logic [3:0] a, input bit wd,
                     input logic [15:0] d, input logic [7:0] ss);
    logic m16, mo, ww, hit;
    logic [1:0] bk;
    logic [3:0] a0, a1;
    logic [7:0] b0, b1, d0, d1, clr;
    logic [15:0] e;
    string tag;
    @(negedge clk);
    cs = 1'b1; we = w; addr = a; wide = wd; wdata = d; status_set = ss;
    rx_rdata = 16'($urandom);
    #1;
    m16 = mdir[6][0]; mo = mdir[6][1]; bk = mdir[7][3:2];
    ww = wd && m16;
    a0 = ww ? {a[3:1], 1'b0} : a;
    a1 = {a[3:1], 1'b1};
    hit = (bk == 2'b10) && (a0 == 4'd8);
    d0 = (ww && mo) ? d[15:8] : d[7:0];
    d1 = mo ? d[7:0] : d[15:8];
    got = rdata;
    if (!w) begin
      b0 = hit ? rx_rdata[7:0]  : mbyte(a0, bk);
      b1 = hit ? rx_rdata[15:8] : mbyte(a1, bk);
      e  = !ww ? {8'h00, b0} : (mo ? {b0, b1} : {b1, b0});
      if (hit) tag = "R5 read port";
      else if (a[3] && bk == 2'b11) tag = "R3 dead bank read";
      else if (a[3]) tag = "R4 bank read";
      else if (ww) tag = "R7 word read";
      else tag = "R6/R2 byte read";
      chk(tag, rdata, e);
    end else begin
      chk("R1 rdata idle on write", rdata, 16'h0000);
    end
    chk("R11 tx_push", tx_push, w && hit);
    chk("R11 rx_pop", rx_pop, !w && hit);
    if (hit) begin
      chk("R8 two-byte flag", w ? tx_two : rx_two, ww);
      if (w) chk("R8 tx_data", tx_data, ww ? {d1, d0} : {8'h00, d0});
    end
    clr = 8'h00;
    if (w && !hit) begin
      for (int l = 0; l < 2; l++) begin
        logic [3:0] la;
        logic [7:0] v;
        if (l == 1 && !ww) continue;
        la = (l == 0) ? a0 : a1;
        v  = (l == 0) ? d0 : d1;
        if (!la[3]) begin
          if (la[2:0] == 3'd0) clr = v; else mdir[la[2:0]] = v;
        end else if (bk == 2'b00) mba[la[2:0]] = v;
        else if (bk == 2'b01) mbb[la[2:0]] = v;
      end
    end
    mdir[0] = (mdir[0] & ~clr) | ss;
    @(posedge clk);
    #1;
    cs = 1'b0; status_set = 8'h00;
    chk("R10 irq", irq, |(mdir[0] & mdir[1]));
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) begin mdir[i] = 0; mba[i] = 0; mbb[i] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq in reset", irq, 1'b0);
    chk("R1 rdata in reset", rdata, 16'h0000);
    chk("R1 strobes in reset", {tx_push, rx_pop}, 2'b00);
    @(negedge clk); rst_n = 1'b1;
    acc(0, 4'd7, 0, 0, 0); chk("R1 bank byte after reset", got, 16'h0000);
    acc(0, 4'd6, 0, 0, 0); chk("R1 config after reset", got, 16'h0000);

    acc(1, 4'd6, 0, 16'h0001, 0);
    acc(1, 4'd2, 1, 16'hBEEF, 0);
    acc(0, 4'd3, 1, 0, 0); chk("R7 lsb-first word", got, 16'hBEEF);
    acc(0, 4'd3, 0, 0, 0); chk("R7 upper lane stored at odd offset", got, 16'h00BE);
    acc(1, 4'd6, 0, 16'h0003, 0);
    acc(0, 4'd2, 1, 0, 0); chk("R7 msb-first word", got, 16'hEFBE);

    acc(1, 4'd7, 0, 16'h0000, 0);
    acc(1, 4'd9, 0, 16'h0011, 0);
    acc(1, 4'd7, 0, 16'h0004, 0);
    acc(1, 4'd9, 0, 16'h0022, 0);
    acc(0, 4'd9, 0, 0, 0); chk("R4 hash bank byte", got, 16'h0022);
    acc(1, 4'd7, 0, 16'h0000, 0);
    acc(0, 4'd9, 0, 0, 0); chk("R4 address bank untouched", got, 16'h0011);
    acc(0, 4'd5, 0, 0, 0); chk("R2 direct read in bank 00", got, 16'h0000);

    acc(1, 4'd7, 0, 16'h000C, 0);
    acc(1, 4'd9, 0, 16'h0077, 0);
    acc(0, 4'd9, 0, 0, 0); chk("R3 dead bank reads zero", got, 16'h0000);
    acc(1, 4'd7, 0, 16'h0000, 0);
    acc(0, 4'd9, 0, 0, 0); chk("R3 dead bank write ignored", got, 16'h0011);

    acc(1, 4'd7, 0, 16'h0008, 0);
    acc(1, 4'd8, 1, 16'h1234, 0);
    acc(0, 4'd8, 1, 0, 0);
    acc(0, 4'd10, 0, 0, 0); chk("R5 other port offsets zero", got, 16'h0000);
    acc(1, 4'd6, 0, 16'h0000, 0);
    acc(1, 4'd8, 1, 16'hA55A, 0);
    acc(0, 4'd8, 1, 0, 0); chk("R6 8-bit upper byte zero", got[15:8], 8'h00);

    acc(1, 4'd1, 0, 16'h0080, 8'h81);
    chk("R10 irq asserted", irq, 1'b1);
    acc(1, 4'd0, 0, 16'h0080, 0);
    chk("R10 irq cleared", irq, 1'b0);
    acc(0, 4'd0, 0, 0, 0); chk("R9 unmasked bit kept", got, 16'h0001);
    acc(1, 4'd0, 0, 16'h0001, 8'h01);
    acc(0, 4'd0, 0, 0, 0); chk("R9 set beats clear", got, 16'h0001);

    for (int n = 0; n < 4000; n++) begin
      logic [3:0] ra;
      ra = 4'($urandom);
      if (ra == 4'd6 && ($urandom % 4) != 0) ra = 4'd8;
      acc(1'($urandom), ra, 1'($urandom), 16'($urandom),
          (($urandom % 6) == 0) ? 8'($urandom) : 8'h00);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule